// File: doc/BRIEF.md
# Debounced Alarm Event Pipeline

This block sits between the health monitors of a clock-conditioning subsystem and the logic that logs alarms and acts on them. Every cycle it receives six raw health flags: lock lost, phase step, frequency offset, missing pulse, temperature out of range and supply rail low. Each flag is filtered by a counter-based debouncer. The rising edges of the filtered alarm state are then correlated, rate-limited and ordered. The result is a stream of event records. Each record carries a running identifier, a timestamp, a class, a reason code, the chosen action and the alarm state vector on either side of the event.

A power-sequencing input marks the bring-up interval. While it is high, the four secondary sources need a debounce period four times as long, and at most a programmable number of their events is let through per interval. Rejected events are counted. Lock loss and missing pulse keep their normal filtering and are never throttled. A switch-over action is only issued when a lock loss and a phase step are both seen within a programmable correlation window.

Top module: `alarm_event_pipe`

## Requirements
- R1: Let L be the source's `deb_len_i` entry, with values below 2 treated as 2. An `alarm_state_o` bit sets only after its flag has been high for L consecutive cycles. It clears only after the flag has been low for L consecutive cycles. A flag pulse shorter than L changes nothing and emits no event.
- R2: While `pwr_seq_i` is high, the secondary sources (phase step, frequency offset, temperature, rail) debounce over 4·L cycles. Lock loss and missing pulse keep L and are never rate-limited.
- R3: Source indices and reason codes are: 0 lock lost, 1 phase step, 2 frequency offset, 3 missing pulse, 4 temperature, 5 rail low. Each accepted rise of an alarm state bit yields one record. `ev_valid_o` is high for one cycle, on the clock after the bit sets. When several records are pending, the lowest index goes first.
- R4: Class codes are 0 time integrity (sources 0, 1, 3), 1 reference health (source 2) and 2 hardware health (sources 4, 5). Action codes are 0 log-only, 1 degrade and 2 switch. Hardware events log only. Reference events and unconfirmed time events degrade.
- R5: A lock-lost or phase-step event takes action 2 when the other of the two rose in the same cycle or at most `corr_win_i` cycles earlier. Outside that window it degrades.
- R6: While `pwr_seq_i` is high, at most `rl_max_i` secondary events are accepted per `rl_intv_i` cycles, counted from the start of the window. Same-cycle requests are served from the lowest index up. The rest are dropped and emit nothing.
- R7: `drop_cnt_o` counts dropped events, saturates at its maximum and never decreases while out of reset.
- R8: The first record after reset has ID 0. Each further record has the previous ID plus one, modulo 2^16.
- R9: `ev_ts_o` is the `ts_i` value sampled on the emitting clock. `ev_state_before_o` is the alarm state just before the source's bit set. `ev_state_after_o` is the alarm state on the emitting clock.
- R10: During reset, `ev_valid_o`, `alarm_state_o` and `drop_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 6 | Raw health flags, indexed by source |
| pwr_seq_i | input | 1 | Power-sequencing window active |
| ts_i | input | 32 | Free-running timestamp |
| deb_len_i | input | 6x8 | Debounce length per source |
| corr_win_i | input | 8 | Correlation window in cycles |
| rl_max_i | input | 4 | Secondary events allowed per interval |
| rl_intv_i | input | 16 | Rate-limit interval in cycles (at least 1) |
| ev_valid_o | output | 1 | Event record valid |
| ev_id_o | output | 16 | Event identifier |
| ev_ts_o | output | 32 | Event timestamp |
| ev_cls_o | output | 2 | Class code |
| ev_reason_o | output | 3 | Reason code (source index) |
| ev_act_o | output | 2 | Action code |
| ev_state_before_o | output | 6 | Alarm state before the event |
| ev_state_after_o | output | 6 | Alarm state at emission |
| alarm_state_o | output | 6 | Debounced alarm state |
| drop_cnt_o | output | 4 | Saturating count of dropped events |

## Verification
The checker assumes that flags are synchronous to the clock and that reset is asserted at time zero. It also assumes that configuration inputs change only while every flag is idle and no record is pending. The bench changes settings only after long quiet gaps, when all flags have been low well past their clear time. It lowers the power-sequencing input for two cycles between vectors, so that each window's rate budget starts fresh. The rate-limit interval is always held at one or more.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NSRC = 6;

  typedef enum logic [1:0] {CLS_TIME = 2'd0, CLS_REF = 2'd1, CLS_HW = 2'd2} cls_e;
  typedef enum logic [1:0] {ACT_LOG = 2'd0, ACT_DEGRADE = 2'd1, ACT_SWITCH = 2'd2} act_e;

  // lock lost (0) and missing pulse (3) bypass window handling
  localparam logic [NSRC-1:0] HARD_MASK = 6'b001001;

  function automatic cls_e src_class(input int s);
    case (s)
      2:       return CLS_REF;
      4, 5:    return CLS_HW;
      default: return CLS_TIME;
    endcase
  endfunction
endpackage

// File: rtl/alarm_debounce.sv
module alarm_debounce #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flag_i,
  input  logic          harsh_i,
  input  logic [CW-1:0] len_i,
  output logic          state_o,
  output logic          rise_o
);
  localparam int EW = CW + 2;

  logic [EW-1:0] base, eff, cnt_q;
  logic          differ, done;

  always_comb begin
    base   = (len_i < CW'(2)) ? EW'(2) : EW'(len_i);
    eff    = harsh_i ? (base << 2) : base;
    differ = flag_i != state_o;
    done   = differ && (cnt_q >= eff - EW'(1));
    rise_o = done && flag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= 1'b0;
      cnt_q   <= '0;
    end else if (done) begin
      state_o <= flag_i;
      cnt_q   <= '0;
    end else if (differ) begin
      cnt_q   <= cnt_q + EW'(1);
    end else begin
      cnt_q   <= '0;
    end
  end
endmodule

// File: rtl/alarm_correlator.sv
module alarm_correlator #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_a_i,
  input  logic          rise_b_i,
  input  logic [CW-1:0] win_i,
  output logic          conf_a_o,
  output logic          conf_b_o
);
  logic          open_q, first_b_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  always_comb begin
    conf_a_o = rise_a_i && (rise_b_i || (open_q && first_b_q));
    conf_b_o = rise_b_i && (rise_a_i || (open_q && !first_b_q));
    nxt      = {1'b0, cnt_q} + (CW+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      first_b_q <= 1'b0;
      cnt_q     <= '0;
    end else if (conf_a_o || conf_b_o) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      cnt_q <= nxt[CW-1:0];
      if (nxt >= {1'b0, win_i}) open_q <= 1'b0;
    end else if (rise_a_i ^ rise_b_i) begin
      open_q    <= win_i != '0;
      first_b_q <= rise_b_i;
      cnt_q     <= '0;
    end
  end
endmodule

// File: rtl/alarm_rate_limiter.sv
module alarm_rate_limiter #(
  parameter int NSRC = 6,
  parameter int RW   = 4,
  parameter int IW   = 16,
  parameter int DW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [RW-1:0]   max_i,
  input  logic [IW-1:0]   intv_i,
  output logic [NSRC-1:0] acc_o,
  output logic [DW-1:0]   drop_cnt_o
);
  localparam int NDW = $clog2(NSRC + 1);
  localparam logic [DW:0] DMAX = {1'b0, {DW{1'b1}}};

  logic [RW-1:0]  cnt_q, taken;
  logic [IW-1:0]  tmr_q;
  logic [NDW-1:0] ndrop;
  logic [DW:0]    sum;

  always_comb begin
    taken = cnt_q;
    ndrop = '0;
    acc_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i]) begin
        if (taken < max_i) begin
          acc_o[i] = 1'b1;
          taken    = taken + RW'(1);
        end else begin
          ndrop = ndrop + NDW'(1);
        end
      end
    end
    sum = {1'b0, drop_cnt_o} + (DW+1)'(ndrop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tmr_q      <= '0;
      drop_cnt_o <= '0;
    end else begin
      drop_cnt_o <= (sum > DMAX) ? DMAX[DW-1:0] : sum[DW-1:0];
      if (!pwr_i) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else if (tmr_q >= intv_i - IW'(1)) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else begin
        cnt_q <= taken;
        tmr_q <= tmr_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/alarm_event_pipe.sv
module alarm_event_pipe
  import alarm_pkg::*;
#(
  parameter int CW  = 8,
  parameter int TSW = 32,
  parameter int IDW = 16,
  parameter int RW  = 4,
  parameter int IW  = 16,
  parameter int DW  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSRC-1:0]          flag_i,
  input  logic                     pwr_seq_i,
  input  logic [TSW-1:0]           ts_i,
  input  logic [NSRC-1:0][CW-1:0]  deb_len_i,
  input  logic [CW-1:0]            corr_win_i,
  input  logic [RW-1:0]            rl_max_i,
  input  logic [IW-1:0]            rl_intv_i,
  output logic                     ev_valid_o,
  output logic [IDW-1:0]           ev_id_o,
  output logic [TSW-1:0]           ev_ts_o,
  output logic [1:0]               ev_cls_o,
  output logic [2:0]               ev_reason_o,
  output logic [1:0]               ev_act_o,
  output logic [NSRC-1:0]          ev_state_before_o,
  output logic [NSRC-1:0]          ev_state_after_o,
  output logic [NSRC-1:0]          alarm_state_o,
  output logic [DW-1:0]            drop_cnt_o
);
  logic [NSRC-1:0] st, rise, harsh, rl_req, rl_acc, acc, conf, pend_q, sw_q, sel_oh;
  logic [NSRC-1:0] before_q [NSRC];
  logic [2:0]      sel;
  logic [IDW-1:0]  id_q;
  logic            conf_lock, conf_phase;
  cls_e            sel_cls;
  act_e            sel_act;

  assign harsh = {NSRC{pwr_seq_i}} & ~HARD_MASK;

  for (genvar g = 0; g < NSRC; g++) begin : g_deb
    alarm_debounce #(.CW(CW)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flag_i  (flag_i[g]),
      .harsh_i (harsh[g]),
      .len_i   (deb_len_i[g]),
      .state_o (st[g]),
      .rise_o  (rise[g])
    );
  end

  alarm_correlator #(.CW(CW)) u_corr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_a_i (rise[0]),
    .rise_b_i (rise[1]),
    .win_i    (corr_win_i),
    .conf_a_o (conf_lock),
    .conf_b_o (conf_phase)
  );

  assign rl_req = rise & ~HARD_MASK & {NSRC{pwr_seq_i}};

  alarm_rate_limiter #(.NSRC(NSRC), .RW(RW), .IW(IW), .DW(DW)) u_rl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_i      (pwr_seq_i),
    .req_i      (rl_req),
    .max_i      (rl_max_i),
    .intv_i     (rl_intv_i),
    .acc_o      (rl_acc),
    .drop_cnt_o (drop_cnt_o)
  );

  always_comb begin
    conf = '0;
    conf[0] = conf_lock;
    conf[1] = conf_phase;
    acc = pwr_seq_i ? ((rise & HARD_MASK) | rl_acc) : rise;
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = 3'(i);
    end
    sel_oh  = (pend_q != '0) ? (NSRC'(1) << sel) : '0;
    sel_cls = src_class(int'(sel));
    if (sw_q[sel])              sel_act = ACT_SWITCH;
    else if (sel_cls == CLS_HW) sel_act = ACT_LOG;
    else                        sel_act = ACT_DEGRADE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q            <= '0;
      sw_q              <= '0;
      id_q              <= '0;
      ev_valid_o        <= 1'b0;
      ev_id_o           <= '0;
      ev_ts_o           <= '0;
      ev_cls_o          <= '0;
      ev_reason_o       <= '0;
      ev_act_o          <= '0;
      ev_state_before_o <= '0;
      ev_state_after_o  <= '0;
      for (int i = 0; i < NSRC; i++) before_q[i] <= '0;
    end else begin
      pend_q <= (pend_q & ~sel_oh) | acc;
      for (int i = 0; i < NSRC; i++) begin
        if (acc[i]) begin
          sw_q[i]     <= conf[i];
          before_q[i] <= st;
        end
      end
      ev_valid_o <= pend_q != '0;
      if (pend_q != '0) begin
        id_q              <= id_q + IDW'(1);
        ev_id_o           <= id_q;
        ev_ts_o           <= ts_i;
        ev_cls_o          <= sel_cls;
        ev_reason_o       <= sel;
        ev_act_o          <= sel_act;
        ev_state_before_o <= before_q[sel];
        ev_state_after_o  <= st;
      end
    end
  end

  assign alarm_state_o = st;
endmodule

// File: rtl/alarm_event_pipe_chk.sv
module alarm_event_pipe_chk #(
  parameter int IDW = 16,
  parameter int DW  = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [5:0]     flag_i,
  input logic           pwr_seq_i,
  input logic           ev_valid_o,
  input logic [IDW-1:0] ev_id_o,
  input logic [1:0]     ev_cls_o,
  input logic [2:0]     ev_reason_o,
  input logic [1:0]     ev_act_o,
  input logic [5:0]     alarm_state_o,
  input logic [DW-1:0]  drop_cnt_o
);
  logic [IDW-1:0] exp_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         exp_id <= '0;
    else if (ev_valid_o) exp_id <= ev_id_o + IDW'(1);
  end

  for (genvar g = 0; g < 6; g++) begin : g_src
    // R1
    rise_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_state_o[g]) |-> ($past(flag_i[g], 1) && $past(flag_i[g], 2)));
    // R1
    fall_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(alarm_state_o[g]) |-> (!$past(flag_i[g], 1) && !$past(flag_i[g], 2)));
  end

  // R8
  id_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> ev_id_o == exp_id);

  // R4
  hw_log_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && ev_cls_o == 2'd2) |-> ev_act_o == 2'd0);

  // R5
  switch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && ev_act_o == 2'd2) |-> ev_reason_o <= 3'd1);

  // R7
  drop_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_cnt_o >= $past(drop_cnt_o));

  // R6
  drop_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_seq_i |=> $stable(drop_cnt_o));
endmodule

bind alarm_event_pipe alarm_event_pipe_chk #(.IDW(IDW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flag_i        (flag_i),
  .pwr_seq_i     (pwr_seq_i),
  .ev_valid_o    (ev_valid_o),
  .ev_id_o       (ev_id_o),
  .ev_cls_o      (ev_cls_o),
  .ev_reason_o   (ev_reason_o),
  .ev_act_o      (ev_act_o),
  .alarm_state_o (alarm_state_o),
  .drop_cnt_o    (drop_cnt_o)
);

// File: tb/tb_alarm_event_pipe.sv
module tb_alarm_event_pipe;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [5:0]       flags = '0;
  logic             pwr = 1'b0;
  logic [31:0]      ts = '0;
  logic [5:0][7:0]  deb_len = {6{8'd4}};
  logic [7:0]       corr_win = 8'd3;
  logic [3:0]       rl_max = 4'd1;
  logic [15:0]      rl_intv = 16'd1000;
  logic             ev_valid;
  logic [15:0]      ev_id;
  logic [31:0]      ev_ts;
  logic [1:0]       ev_cls, ev_act;
  logic [2:0]       ev_reason;
  logic [5:0]       ev_bef, ev_aft, a_state;
  logic [3:0]       drop_cnt;

  int tests = 0;
  int fails = 0;
  int ev_n  = 0;
  logic        have_prev = 1'b0;
  logic        saw_wrap  = 1'b0;
  logic [15:0] prev_id   = '0;
  logic [2:0]  lg_rsn [8];
  logic [1:0]  lg_act [8];
  logic [1:0]  lg_cls [8];
  logic [5:0]  lg_bef [8];
  logic [5:0]  lg_aft [8];

  always #5 clk = ~clk;
  always @(posedge clk) ts <= ts + 32'd1;

  alarm_event_pipe dut (
    .clk_i (clk), .rst_ni (rst_n), .flag_i (flags), .pwr_seq_i (pwr), .ts_i (ts),
    .deb_len_i (deb_len), .corr_win_i (corr_win), .rl_max_i (rl_max), .rl_intv_i (rl_intv),
    .ev_valid_o (ev_valid), .ev_id_o (ev_id), .ev_ts_o (ev_ts), .ev_cls_o (ev_cls),
    .ev_reason_o (ev_reason), .ev_act_o (ev_act), .ev_state_before_o (ev_bef),
    .ev_state_after_o (ev_aft), .alarm_state_o (a_state), .drop_cnt_o (drop_cnt)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // event monitor: ID sequence (R8), timestamp (R9), log of first records
  always @(negedge clk) begin
    if (rst_n && ev_valid) begin
      check("R8 id sequence", ev_id, have_prev ? 16'(prev_id + 16'd1) : 16'd0);
      check("R9 timestamp", ev_ts, ts - 32'd1);
      if (have_prev && ev_id == 16'd0) saw_wrap = 1'b1;
      have_prev = 1'b1;
      prev_id   = ev_id;
      if (ev_n < 8) begin
        lg_rsn[ev_n] = ev_reason;
        lg_act[ev_n] = ev_act;
        lg_cls[ev_n] = ev_cls;
        lg_bef[ev_n] = ev_bef;
        lg_aft[ev_n] = ev_aft;
      end
      ev_n++;
    end
  end

  typedef struct packed {
    logic       pwr;
    logic [5:0] flg;
    logic [7:0] hold;
    logic [3:0] n;
    logic [2:0] rsn;
    logic [1:0] act;
    logic [1:0] cls;
  } vec_t;

  // R1 R2 R3 R4 R5 vectors, debounce length 4
  localparam vec_t VEC [11] = '{
    '{1'b0, 6'h01, 8'd4,  4'd1, 3'd0, 2'd1, 2'd0},
    '{1'b0, 6'h01, 8'd3,  4'd0, 3'd0, 2'd0, 2'd0},
    '{1'b0, 6'h04, 8'd4,  4'd1, 3'd2, 2'd1, 2'd1},
    '{1'b0, 6'h10, 8'd6,  4'd1, 3'd4, 2'd0, 2'd2},
    '{1'b0, 6'h03, 8'd4,  4'd2, 3'd0, 2'd2, 2'd0},
    '{1'b0, 6'h08, 8'd1,  4'd0, 3'd0, 2'd0, 2'd0},
    '{1'b0, 6'h20, 8'd4,  4'd1, 3'd5, 2'd0, 2'd2},
    '{1'b1, 6'h10, 8'd4,  4'd0, 3'd0, 2'd0, 2'd0},
    '{1'b1, 6'h01, 8'd4,  4'd1, 3'd0, 2'd1, 2'd0},
    '{1'b1, 6'h10, 8'd16, 4'd1, 3'd4, 2'd0, 2'd2},
    '{1'b1, 6'h08, 8'd4,  4'd1, 3'd3, 2'd1, 2'd0}
  };

  task automatic corr_run(input int off, input logic [1:0] exp_act);
    @(negedge clk);
    ev_n = 0;
    flags = 6'h01;
    repeat (off) @(negedge clk);
    flags = 6'h03;
    repeat (10) @(negedge clk);
    flags = '0;
    repeat (40) @(negedge clk);
    check("R5 corr event count", ev_n, 2);
    check("R5 lock event degrades", lg_act[0], 1);
    check("R5 phase event action", lg_act[1], exp_act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid in reset", ev_valid, 0);
    check("R10 state in reset", a_state, 0);
    check("R10 drops in reset", drop_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      pwr   = VEC[i].pwr;
      ev_n  = 0;
      flags = VEC[i].flg;
      repeat (VEC[i].hold) @(negedge clk);
      flags = '0;
      repeat (40) @(negedge clk);
      check($sformatf("R1/R2/R3 vec %0d event count", i), ev_n, VEC[i].n);
      if (VEC[i].n != 0) begin
        check($sformatf("R3 vec %0d reason", i), lg_rsn[0], VEC[i].rsn);
        check($sformatf("R4/R5 vec %0d action", i), lg_act[0], VEC[i].act);
        check($sformatf("R4 vec %0d class", i), lg_cls[0], VEC[i].cls);
      end
      if (i == 4) begin
        check("R3 second reason", lg_rsn[1], 1);
        check("R5 second action", lg_act[1], 2);
        check("R9 state before", lg_bef[0], 0);
        check("R9 state after", lg_aft[0], 3);
      end
      pwr = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R5 correlation window boundaries (window 3)
    corr_run(2, 2'd2);
    corr_run(3, 2'd2);
    corr_run(5, 2'd1);

    // R1 clear needs L low cycles; short gap neither clears nor re-emits
    @(negedge clk);
    ev_n = 0;
    flags = 6'h01;
    repeat (4) @(negedge clk);
    check("R1 set after 4 high", a_state[0], 1);
    flags = '0;
    repeat (3) @(negedge clk);
    check("R1 held after 3 low", a_state[0], 1);
    flags = 6'h01;
    repeat (6) @(negedge clk);
    check("R1 no re-emit on short gap", ev_n, 1);
    flags = '0;
    repeat (3) @(negedge clk);
    check("R1 still set after 3 low", a_state[0], 1);
    @(negedge clk);
    check("R1 clear after 4 low", a_state[0], 0);
    repeat (20) @(negedge clk);

    // R6 rate limit: three secondary rises at once, budget 1
    pwr = 1'b1;
    rl_max = 4'd1;
    ev_n = 0;
    flags = 6'h34;
    repeat (16) @(negedge clk);
    flags = '0;
    repeat (40) @(negedge clk);
    check("R6 accepted count", ev_n, 1);
    check("R6 lowest index kept", lg_rsn[0], 2);
    check("R7 drop count", drop_cnt, 2);
    pwr = 1'b0;
    repeat (2) @(negedge clk);

    // R7 saturation with zero budget
    pwr = 1'b1;
    rl_max = 4'd0;
    ev_n = 0;
    for (int b = 0; b < 5; b++) begin
      flags = 6'h36;
      repeat (16) @(negedge clk);
      flags = '0;
      repeat (24) @(negedge clk);
    end
    check("R6 zero budget emits none", ev_n, 0);
    check("R7 drop saturates", drop_cnt, 15);
    pwr = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 drop holds", drop_cnt, 15);

    // R8 ID wrap: dense toggling with length 2
    deb_len = {6{8'd2}};
    repeat (2) @(negedge clk);
    for (int k = 0; k < 17000; k++) begin
      flags = 6'h3F;
      repeat (2) @(negedge clk);
      flags = '0;
      repeat (2) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check("R8 id wrapped", saw_wrap, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule